// File: doc/BRIEF.md
# Transition-Triggered ROM Read Sequencer

This block is a clocked model of a byte-wide read-only memory front end. It does not read on every clock. Each clock it samples a 19-bit word address, an active-low chip enable and an active-low output enable. An internal read starts only when a change is detected: either the address moves while the chip is enabled, or the chip enable falls. The read then completes after a fixed number of clock cycles. That latency is longer for an address-started read than for one started by chip enable.

The word that was read leaves the block as a data bus together with a drive flag, which stands in for a three-state output. The drive flag follows the two enables through its own turn-on and turn-off delays. A status output says whether the data bus holds the word for the current address. A second output reports standby whenever chip enable is high.

Because reads start only on transitions, the data bus stays invalid after reset until the address or chip enable changes. A new transition that arrives during a read restarts that read for the new address.

Top module: `trom_seq_top`

## Requirements
- R1: The array holds 2^19 words of 8 bits. The word at address `a` is `a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A`. A completed read places this word on `dout_o`, and `dout_o` keeps it until the next read completes. `dout_o` is 0 after reset.
- R2: Suppose chip enable is low and the sampled address differs from the previous sample at clock edge E. Then `data_valid_o` rises, with the new word on `dout_o`, after edge E + ADDR_LAT.
- R3: Suppose chip enable is sampled high at one edge and low at edge E. Then a read of the current address completes after edge E + CE_LAT. CE_LAT is no larger than ADDR_LAT.
- R4: The first clock edge after reset only records the inputs. With inputs held constant after reset, no read starts and `data_valid_o` stays 0.
- R5: A new transition while a read is pending restarts that read's latency from its own edge, for the new address. The abandoned address never produces a `data_valid_o` rise.
- R6: When a read starts at edge E, `data_valid_o` keeps its value for HOLD_LAT cycles and reads 0 after edge E + HOLD_LAT, until the read completes. HOLD_LAT must be below both read latencies.
- R7: Suppose chip enable and output enable are both sampled low at edge E, after being not both low. Then `dout_oe_o` turns on after edge E + OE_LAT, provided both stay low.
- R8: If either enable is sampled high at edge E while `dout_oe_o` is on, `dout_oe_o` turns off after edge E + DIS_LAT. If both return low before that, it stays on.
- R9: `standby_o` is 1 exactly when chip enable was high at the last edge. With chip enable low and output enable high, `standby_o` is 0 and the drive turns off per R8.
- R10: Address changes while chip enable is high start no read, and they leave `data_valid_o` and `dout_o` unchanged. Chip enable high also cancels a pending read.
- R11: During reset, `data_valid_o` and `dout_oe_o` are 0 and `standby_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 19 | Word address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dout_o | output | 8 | Data word last read |
| dout_oe_o | output | 1 | Output drive flag (1 = bus driven) |
| data_valid_o | output | 1 | `dout_o` holds the word for the current address |
| standby_o | output | 1 | Chip enable was high at the last edge |

## Verification
On every cycle, the embedded assertions check several local rules:
- the validity flag changes only while a read is pending;
- the drive flag rises only after enabled samples and falls only after a disabled sample;
- triggers occur only with chip enable low;
- the latency counter stays inside its range.

Other behaviour only the bench's scenarios can show. This covers the exact completion cycles for address-started and enable-started reads, the data value read, the restart that drops an abandoned address, and the hold window. It also covers the silence after reset and address moves during standby, which leave the outputs untouched.

// File: rtl/trom_seq_pkg.sv
package trom_seq_pkg;

  typedef enum logic {
    SRC_ADDR = 1'b0,
    SRC_CE   = 1'b1
  } trig_src_e;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_RISE = 2'd1,
    DRV_ON   = 2'd2,
    DRV_FALL = 2'd3
  } drv_state_e;

endpackage

// File: rtl/trom_trans_detect.sv
module trom_trans_detect
  import trom_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  output logic              trig_o,
  output trig_src_e         src_o,
  output logic              ce_n_q_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ce_n_q, ce_n_d;
  logic              armed_q, armed_d;
  logic              addr_chg, ce_fall;

  always_comb begin
    addr_d  = addr_i;
    ce_n_d  = ce_n_i;
    armed_d = 1'b1;
    addr_chg = armed_q && !ce_n_i && (addr_i != addr_q);
    ce_fall  = armed_q && ce_n_q && !ce_n_i;
    trig_o   = addr_chg || ce_fall;
    src_o    = ce_fall ? SRC_CE : SRC_ADDR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      ce_n_q  <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      ce_n_q  <= ce_n_d;
      armed_q <= armed_d;
    end
  end

  assign ce_n_q_o = ce_n_q;

endmodule

// File: rtl/trom_read_seq.sv
module trom_read_seq
  import trom_seq_pkg::*;
#(
  parameter int              ADDR_W   = 19,
  parameter int              DATA_W   = 8,
  parameter int              ADDR_LAT = 6,
  parameter int              CE_LAT   = 4,
  parameter int              HOLD_LAT = 1,
  parameter logic [DATA_W-1:0] SEED   = 'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  trig_src_e         src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  localparam int MAX_LAT = (ADDR_LAT > CE_LAT) ?
                           ((ADDR_LAT > HOLD_LAT) ? ADDR_LAT : HOLD_LAT) :
                           ((CE_LAT > HOLD_LAT) ? CE_LAT : HOLD_LAT);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam int NSLICE  = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int EXT_W   = NSLICE * DATA_W;

  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  hold_q, hold_d;
  logic [ADDR_W-1:0] lat_addr_q, lat_addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;

  // Array contents are computed: XOR fold of the address slices with a seed
  logic [EXT_W-1:0]  addr_ext;
  logic [DATA_W-1:0] slice_x [NSLICE+1];
  assign addr_ext   = EXT_W'(lat_addr_q);
  assign slice_x[0] = SEED;
  for (genvar s = 0; s < NSLICE; s++) begin : g_fold
    assign slice_x[s+1] = slice_x[s] ^ addr_ext[s*DATA_W +: DATA_W];
  end

  always_comb begin
    pend_d     = pend_q;
    cnt_d      = cnt_q;
    hold_d     = hold_q;
    lat_addr_d = lat_addr_q;
    data_d     = data_q;
    valid_d    = valid_q;
    if (trig_i) begin
      pend_d     = 1'b1;
      cnt_d      = (src_i == SRC_CE) ? CNT_W'(CE_LAT) : CNT_W'(ADDR_LAT);
      hold_d     = CNT_W'(HOLD_LAT);
      lat_addr_d = addr_i;
      if (HOLD_LAT == 0) valid_d = 1'b0;
    end else if (ce_n_i) begin
      pend_d = 1'b0;
      hold_d = '0;
    end else if (pend_q) begin
      if (hold_q == CNT_W'(1)) valid_d = 1'b0;
      if (hold_q != '0) hold_d = hold_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        pend_d  = 1'b0;
        data_d  = slice_x[NSLICE];
        valid_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      cnt_q      <= '0;
      hold_q     <= '0;
      lat_addr_q <= '0;
      data_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      cnt_q      <= cnt_d;
      hold_q     <= hold_d;
      lat_addr_q <= lat_addr_d;
      data_q     <= data_d;
      valid_q    <= valid_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  assert_valid_rise_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(pend_q) && !pend_q);

  assert_valid_fall_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |-> pend_q);

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(MAX_LAT)));

endmodule

// File: rtl/trom_drive_ctl.sv
module trom_drive_ctl
  import trom_seq_pkg::*;
#(
  parameter int OE_LAT  = 2,
  parameter int DIS_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_i,
  input  logic oe_n_i,
  output logic drive_o
);

  localparam int MAX_D  = (OE_LAT > DIS_LAT) ? OE_LAT : DIS_LAT;
  localparam int DCNT_W = $clog2(MAX_D + 1);

  drv_state_e        state_q, state_d;
  logic [DCNT_W-1:0] tcnt_q, tcnt_d;
  logic              en;

  assign en = !ce_n_i && !oe_n_i;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    unique case (state_q)
      DRV_OFF: if (en) begin
        state_d = DRV_RISE;
        tcnt_d  = DCNT_W'(OE_LAT);
      end
      DRV_RISE: begin
        if (!en) state_d = DRV_OFF;
        else if (tcnt_q == DCNT_W'(1)) state_d = DRV_ON;
        else tcnt_d = tcnt_q - DCNT_W'(1);
      end
      DRV_ON: if (!en) begin
        state_d = DRV_FALL;
        tcnt_d  = DCNT_W'(DIS_LAT);
      end
      DRV_FALL: begin
        if (en) state_d = DRV_ON;
        else if (tcnt_q == DCNT_W'(1)) state_d = DRV_OFF;
        else tcnt_d = tcnt_q - DCNT_W'(1);
      end
      default: state_d = DRV_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DRV_OFF;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
    end
  end

  assign drive_o = (state_q == DRV_ON) || (state_q == DRV_FALL);

  assert_drive_on_after_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_o) |-> $past(en));

  assert_drive_off_after_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_o) |-> !$past(en));

endmodule

// File: rtl/trom_seq_top.sv
module trom_seq_top
  import trom_seq_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int ADDR_LAT = 6,
  parameter int CE_LAT   = 4,
  parameter int OE_LAT   = 2,
  parameter int HOLD_LAT = 1,
  parameter int DIS_LAT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o,
  output logic              data_valid_o,
  output logic              standby_o
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       trig;
  trig_src_e  src;
  logic       ce_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  trom_trans_detect #(.ADDR_W(ADDR_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_ni),
    .addr_i   (addr_i),
    .ce_n_i   (ce_n_i),
    .trig_o   (trig),
    .src_o    (src),
    .ce_n_q_o (ce_n_q)
  );

  trom_read_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ADDR_LAT (ADDR_LAT),
    .CE_LAT   (CE_LAT),
    .HOLD_LAT (HOLD_LAT)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_ni),
    .trig_i  (trig),
    .src_i   (src),
    .addr_i  (addr_i),
    .ce_n_i  (ce_n_i),
    .data_o  (dout_o),
    .valid_o (data_valid_o)
  );

  trom_drive_ctl #(.OE_LAT(OE_LAT), .DIS_LAT(DIS_LAT)) u_drv (
    .clk     (clk),
    .rst_n   (rst_ni),
    .ce_n_i  (ce_n_i),
    .oe_n_i  (oe_n_i),
    .drive_o (dout_oe_o)
  );

  assign standby_o = ce_n_q;

  assert_trig_only_enabled_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    trig |-> !ce_n_i);

endmodule

// File: tb/sim_trom_seq_top.sv
module sim_trom_seq_top;

  localparam int ADDR_LAT = 6;
  localparam int CE_LAT   = 4;
  localparam int OE_LAT   = 2;
  localparam int HOLD_LAT = 1;
  localparam int DIS_LAT  = 3;

  typedef struct {
    int         cyc;
    logic [7:0] data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [18:0] addr;
  logic        ce_n, oe_n;
  logic [7:0]  dout;
  logic        dout_oe, dvalid, standby;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic prev_v = 1'b0;
  exp_t exp_q[$];

  trom_seq_top #(
    .ADDR_LAT(ADDR_LAT), .CE_LAT(CE_LAT), .OE_LAT(OE_LAT),
    .HOLD_LAT(HOLD_LAT), .DIS_LAT(DIS_LAT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .dout_o(dout), .dout_oe_o(dout_oe), .data_valid_o(dvalid), .standby_o(standby)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] word_of(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d act=%0h exp=%0h", req, cyc, act, exp);
    end
  endtask

  // Driver: inputs change 1 ns after a rising edge; next edge E = cyc+1
  task automatic push_read(input int lat, input logic [18:0] a);
    exp_t e;
    if (exp_q.size() > 0) exp_q.delete(exp_q.size() - 1); // restart (R5)
    e.cyc  = cyc + 1 + lat;
    e.data = word_of(a);
    exp_q.push_back(e);
  endtask

  task automatic set_addr(input logic [18:0] a);
    @(posedge clk); #1;
    if (!ce_n && a != addr) push_read(ADDR_LAT, a);
    addr = a;
  endtask

  task automatic set_ce(input logic v);
    @(posedge clk); #1;
    if (ce_n && !v) push_read(CE_LAT, addr);
    ce_n = v;
  endtask

  task automatic set_oe(input logic v);
    @(posedge clk); #1;
    oe_n = v;
  endtask

  task automatic wait_to(input int c);
    while (1) begin
      @(negedge clk);
      if (cyc >= c) break;
    end
  endtask

  task automatic drain;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: each rise of data_valid pops one expected item
  always @(negedge clk) begin
    if (!prev_v && dvalid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected read completion", 32'd1, 32'd0);
      end else begin
        chk("R2/R3 completion cycle", cyc, exp_q[0].cyc);
        chk("R1 data word", {24'd0, dout}, {24'd0, exp_q[0].data});
        exp_q.pop_front();
      end
    end
    prev_v <= dvalid;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int e;
    logic [7:0] held;
    rst_n = 1'b0; addr = '0; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 valid in reset", {31'd0, dvalid}, 32'd0);
    chk("R11 drive in reset", {31'd0, dout_oe}, 32'd0);
    chk("R11 standby in reset", {31'd0, standby}, 32'd1);
    chk("R1 dout in reset", {24'd0, dout}, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R4: constant inputs after reset start nothing
    repeat (12) @(negedge clk);
    chk("R4 no read without transition", {31'd0, dvalid}, 32'd0);
    chk("R9 operating mode", {31'd0, standby}, 32'd0);
    chk("R7 drive on with both enables low", {31'd0, dout_oe}, 32'd1);

    // R2/R1: address-started reads
    set_addr(19'h12345); drain();
    set_addr(19'h7FFFF); drain();
    set_addr(19'h40000); drain();

    // R6: hold window after an address change
    set_addr(19'h00001); e = cyc + 1;
    wait_to(e + HOLD_LAT - 1);
    chk("R6 old data held", {31'd0, dvalid}, 32'd1);
    wait_to(e + HOLD_LAT);
    chk("R6 invalid after hold", {31'd0, dvalid}, 32'd0);
    drain();

    // R5: restart during a pending read
    set_addr(19'h0ABCD);
    @(posedge clk); @(posedge clk);
    set_addr(19'h05555);
    drain();

    // R8: output enable high turns the drive off after DIS_LAT
    set_oe(1'b1); e = cyc + 1;
    wait_to(e + DIS_LAT - 1);
    chk("R8 still driving", {31'd0, dout_oe}, 32'd1);
    wait_to(e + DIS_LAT);
    chk("R8 drive off", {31'd0, dout_oe}, 32'd0);
    chk("R9 no standby with oe high", {31'd0, standby}, 32'd0);

    // R7: output enable low turns the drive on after OE_LAT
    set_oe(1'b0); e = cyc + 1;
    wait_to(e + OE_LAT - 1);
    chk("R7 not yet driving", {31'd0, dout_oe}, 32'd0);
    wait_to(e + OE_LAT);
    chk("R7 driving", {31'd0, dout_oe}, 32'd1);

    // R9: chip enable high -> standby, drive off
    set_ce(1'b1); e = cyc + 1;
    wait_to(e);
    chk("R9 standby on", {31'd0, standby}, 32'd1);
    wait_to(e + DIS_LAT);
    chk("R9 drive off in standby", {31'd0, dout_oe}, 32'd0);

    // R10: address moves in standby are ignored
    held = dout;
    set_addr(19'h33333);
    set_addr(19'h11111);
    repeat (ADDR_LAT + 3) @(negedge clk);
    chk("R10 valid unchanged", {31'd0, dvalid}, 32'd1);
    chk("R10 dout unchanged", {24'd0, dout}, {24'd0, held});

    // R3: chip enable fall reads the current address
    set_ce(1'b0);
    drain();
    chk("R3 standby off", {31'd0, standby}, 32'd0);

    // R2: back to address zero
    set_addr(19'h00000); drain();
    chk("R5 no leftover reads", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule